// File: doc/BRIEF.md
# Serial Port FIFO Pair with Occupancy Index

This block sits between a serial port's register decoder and its bit shifters. It has two queues. The transmit queue holds bytes that software writes and the transmit shifter drains. The receive queue holds 10-bit entries that the receive shifter fills: a data byte plus a parity-error flag and a framing-error flag for that character. Software reads these entries back in arrival order. A packed index word reports the occupancy of both queues. A small control word enables queue mode and flushes either queue through request bits that clear themselves.

The block also drives level and event indications for the interrupt logic: transmit almost-empty and empty, receive almost-full and full, a receive overrun pulse when the receive queue loses a character, and a transmit underrun pulse when the shifter asks an empty queue for data. When queue mode is off, each queue behaves as a single holding register of capacity one. An optional error-on-empty input turns a read of the empty receive queue into a bus error response.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset, both counts are 0, the control word reads 0 (queue mode off), tx_empty and tx_almost_empty are 1, and rx_full, rx_almost_full, rx_overrun, tx_underrun and txs_avail are 0.
- R2: The transmit queue holds up to 16 bytes. They leave through txs_data/txs_pop in the order they were written. A host write to a full transmit queue is dropped. The transmit count is in fifo_index bits 4:0.
- R3: The receive queue holds up to 16 entries of 10 bits: data in bits 7:0, parity error in bit 8, framing error in bit 9. Each entry is returned unchanged on host_rx_data, in arrival order. The receive count is in fifo_index bits 12:8.
- R4: Control bit 0 enables queue mode. While it is 0, each queue accepts at most one entry.
- R5: A shifter push into a full receive queue is dropped, leaves the contents unchanged, and raises rx_overrun for exactly the one cycle after that clock edge.
- R6: A pop of the empty transmit queue is ignored (the count stays 0) and raises tx_underrun for exactly the one cycle after that edge.
- R7: tx_almost_empty is 1 exactly when the transmit count is 4 or less. tx_empty is 1 exactly when it is 0.
- R8: rx_almost_full is 1 exactly when the receive count is 12 or more. rx_full is 1 exactly when the count equals the current capacity (16, or 1 with queue mode off).
- R9: Writing control bit 2 flushes the transmit queue and writing bit 3 flushes the receive queue. The bit reads 1 for the cycle after the write, then reads 0 with that queue's count at 0. The other queue is untouched.
- R10: A host read of the empty receive queue drives host_rx_err in the same cycle when err_on_empty is 1, and leaves it at 0 when err_on_empty is 0. In both cases the count stays 0.
- R11: A push and a pop in the same cycle on a full queue are both accepted, and the count stays at its capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control write data: bit 0 queue mode, bit 2 transmit flush, bit 3 receive flush |
| ctl_rdata | output | 4 | Control word readback |
| err_on_empty | input | 1 | Make a read of the empty receive queue an error |
| host_tx_we | input | 1 | Host write into the transmit queue |
| host_tx_data | input | 8 | Byte to queue for transmission |
| host_rx_re | input | 1 | Host read (pop) of the receive queue |
| host_rx_data | output | 10 | Oldest receive entry |
| host_rx_err | output | 1 | Bus error response for the current read |
| fifo_index | output | 16 | Transmit count in 4:0, receive count in 12:8 |
| txs_pop | input | 1 | Transmit shifter takes a byte |
| txs_data | output | 8 | Oldest transmit byte |
| txs_avail | output | 1 | Transmit queue not empty |
| rxs_push | input | 1 | Receive shifter delivers an entry |
| rxs_data | input | 10 | Received entry with error flags |
| tx_almost_empty | output | 1 | Transmit count at or below 4 |
| tx_empty | output | 1 | Transmit queue empty |
| tx_underrun | output | 1 | One-cycle pulse after a pop of the empty queue |
| rx_almost_full | output | 1 | Receive count at or above 12 |
| rx_full | output | 1 | Receive queue at capacity |
| rx_overrun | output | 1 | One-cycle pulse after a lost receive entry |

## Verification
Counts, level flags, head data and the underrun and overrun pulses change on the clock edge that takes the push, pop or flush. They are due one edge after the stimulus. The control readback shows a flush bit one edge after the write, and the cleared bit with the zero count one edge later. host_rx_err is combinational and is due in the same cycle as the read. The bench sets inputs on the falling edge, lets one rising edge pass, and samples at the next falling edge. It samples host_rx_err a moment after it raises the read strobe. It checks every count from 0 to 16 in both queues against counts and data sequences computed in the bench.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
    localparam int TX_WIDTH   = 8;
    localparam int RX_WIDTH   = 10;
    localparam int QDEPTH     = 16;
    localparam int AE_LEVEL   = 4;
    localparam int AF_LEVEL   = 12;
    localparam int CTL_W      = 4;
    localparam int BIT_QMODE  = 0;
    localparam int BIT_TXFL   = 2;
    localparam int BIT_RXFL   = 3;

    typedef struct packed {
        logic qmode;
        logic tx_pend;
        logic rx_pend;
    } ctl_state_t;
endpackage

// File: rtl/ufp_ctl.sv
module ufp_ctl
    import uart_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] rdata,
    output logic             qmode,
    output logic             tx_flush,
    output logic             rx_flush
);
    ctl_state_t s_d, s_q;
    logic ctl_unused;

    assign ctl_unused = wdata[1];

    always_comb begin
        s_d = s_q;
        // a pending flush is carried out during this cycle, then drops
        if (s_q.tx_pend) s_d.tx_pend = 1'b0;
        if (s_q.rx_pend) s_d.rx_pend = 1'b0;
        if (we) begin
            s_d.qmode = wdata[BIT_QMODE];
            if (wdata[BIT_TXFL]) s_d.tx_pend = 1'b1;
            if (wdata[BIT_RXFL]) s_d.rx_pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata            = '0;
        rdata[BIT_QMODE] = s_q.qmode;
        rdata[BIT_TXFL]  = s_q.tx_pend;
        rdata[BIT_RXFL]  = s_q.rx_pend;
    end

    assign qmode    = s_q.qmode;
    assign tx_flush = s_q.tx_pend;
    assign rx_flush = s_q.rx_pend;

    // R9
    txfl_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.tx_pend && !(we && wdata[BIT_TXFL])) |=> !s_q.tx_pend);
    // R9
    rxfl_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rx_pend && !(we && wdata[BIT_RXFL])) |=> !s_q.rx_pend);
endmodule

// File: rtl/ufp_fifo.sv
module ufp_fifo #(
    parameter int W      = 8,
    parameter int DEPTH  = 16,
    parameter int AE_LVL = 4,
    parameter int AF_LVL = 12,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          single,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          almost_empty,
    output logic          almost_full,
    output logic          push_lost,
    output logic          pop_lost
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
        logic [CW-1:0]           cnt;
        logic                    push_lost;
        logic                    pop_lost;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic pop_ok, push_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + PW'(1);
    endfunction

    assign empty        = (s_q.cnt == '0);
    assign full         = single ? (s_q.cnt != '0) : (s_q.cnt >= CW'(DEPTH));
    assign almost_empty = (s_q.cnt <= CW'(AE_LVL));
    assign almost_full  = (s_q.cnt >= CW'(AF_LVL));
    assign pop_ok       = pop && !empty;
    assign push_ok      = push && (!full || pop_ok);

    always_comb begin
        s_d = s_q;
        s_d.push_lost = 1'b0;
        s_d.pop_lost  = 1'b0;
        if (flush) begin
            s_d.wr  = '0;
            s_d.rd  = '0;
            s_d.cnt = '0;
        end else begin
            s_d.push_lost = push && !push_ok;
            s_d.pop_lost  = pop && empty;
            if (push_ok) begin
                s_d.mem[s_q.wr] = push_data;
                s_d.wr          = bump(s_q.wr);
            end
            if (pop_ok) s_d.rd = bump(s_q.rd);
            case ({push_ok, pop_ok})
                2'b10:   s_d.cnt = s_q.cnt + CW'(1);
                2'b01:   s_d.cnt = s_q.cnt - CW'(1);
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head      = s_q.mem[s_q.rd];
    assign count     = s_q.cnt;
    assign push_lost = s_q.push_lost;
    assign pop_lost  = s_q.pop_lost;

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));
    // R5
    lost_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (push_lost && $stable(s_q.cnt)));
    // R6
    lost_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (pop_lost && s_q.cnt == '0));
    // R11
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && full && !flush) |=> (!push_lost && $stable(s_q.cnt)));
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH  = QDEPTH,
    parameter int TXW    = TX_WIDTH,
    parameter int RXW    = RX_WIDTH,
    parameter int AE_LVL = AE_LEVEL,
    parameter int AF_LVL = AF_LEVEL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             err_on_empty,
    input  logic             host_tx_we,
    input  logic [7:0]       host_tx_data,
    input  logic             host_rx_re,
    output logic [9:0]       host_rx_data,
    output logic             host_rx_err,
    output logic [15:0]      fifo_index,
    input  logic             txs_pop,
    output logic [7:0]       txs_data,
    output logic             txs_avail,
    input  logic             rxs_push,
    input  logic [9:0]       rxs_data,
    output logic             tx_almost_empty,
    output logic             tx_empty,
    output logic             tx_underrun,
    output logic             rx_almost_full,
    output logic             rx_full,
    output logic             rx_overrun
);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int PADW = 8 - CW;

    logic          qmode, tx_flush, rx_flush;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          rx_empty, tx_host_drop, rx_read_lost;
    logic          rx_ae_unused, tx_af_unused, tx_full_unused;

    ufp_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
        .rdata(ctl_rdata), .qmode(qmode),
        .tx_flush(tx_flush), .rx_flush(rx_flush)
    );

    ufp_fifo #(.W(TXW), .DEPTH(DEPTH), .AE_LVL(AE_LVL), .AF_LVL(AF_LVL)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .single(!qmode),
        .push(host_tx_we), .push_data(host_tx_data), .pop(txs_pop),
        .head(txs_data), .count(tx_cnt), .empty(tx_empty), .full(tx_full_unused),
        .almost_empty(tx_almost_empty), .almost_full(tx_af_unused),
        .push_lost(tx_host_drop), .pop_lost(tx_underrun)
    );

    ufp_fifo #(.W(RXW), .DEPTH(DEPTH), .AE_LVL(AE_LVL), .AF_LVL(AF_LVL)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .single(!qmode),
        .push(rxs_push), .push_data(rxs_data), .pop(host_rx_re),
        .head(host_rx_data), .count(rx_cnt), .empty(rx_empty), .full(rx_full),
        .almost_empty(rx_ae_unused), .almost_full(rx_almost_full),
        .push_lost(rx_overrun), .pop_lost(rx_read_lost)
    );

    assign txs_avail   = !tx_empty;
    assign host_rx_err = host_rx_re && rx_empty && err_on_empty;
    assign fifo_index  = {{PADW{1'b0}}, rx_cnt, {PADW{1'b0}}, tx_cnt};

    // R2
    tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_host_drop |-> fifo_index[4:0] != 5'd0);
    // R10
    rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rx_re && rx_empty && !rxs_push) |=> (rx_read_lost && fifo_index[12:8] == 5'd0));
endmodule

// File: tb/sim_uart_fifo_pair.sv
module sim_uart_fifo_pair;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [3:0] ctl_wdata = '0;
    logic [3:0] ctl_rdata;
    logic       err_on_empty = 1'b0;
    logic       host_tx_we = 1'b0;
    logic [7:0] host_tx_data = '0;
    logic       host_rx_re = 1'b0;
    logic [9:0] host_rx_data;
    logic       host_rx_err;
    logic [15:0] fifo_index;
    logic       txs_pop = 1'b0;
    logic [7:0] txs_data;
    logic       txs_avail;
    logic       rxs_push = 1'b0;
    logic [9:0] rxs_data = '0;
    logic       tx_almost_empty, tx_empty, tx_underrun;
    logic       rx_almost_full, rx_full, rx_overrun;

    int errors = 0;
    int checks = 0;

    uart_fifo_pair u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .err_on_empty(err_on_empty),
        .host_tx_we(host_tx_we), .host_tx_data(host_tx_data),
        .host_rx_re(host_rx_re), .host_rx_data(host_rx_data),
        .host_rx_err(host_rx_err), .fifo_index(fifo_index),
        .txs_pop(txs_pop), .txs_data(txs_data), .txs_avail(txs_avail),
        .rxs_push(rxs_push), .rxs_data(rxs_data),
        .tx_almost_empty(tx_almost_empty), .tx_empty(tx_empty),
        .tx_underrun(tx_underrun), .rx_almost_full(rx_almost_full),
        .rx_full(rx_full), .rx_overrun(rx_overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one rising edge, then sample at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [9:0] rx_entry(input int k);
        logic [7:0] b;
        b = 8'(k * 7 + 3);
        return {k[0], k[1], b};
    endfunction

    task automatic ctl_write(input logic [3:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        step();
        ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int rx_tx_cnt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ctl", int'(ctl_rdata), 0);
        check("R1 index", int'(fifo_index), 0);
        check("R1 tx_empty", int'(tx_empty), 1);
        check("R1 tx_almost_empty", int'(tx_almost_empty), 1);
        check("R1 flags", int'({rx_full, rx_almost_full, rx_overrun, tx_underrun, txs_avail}), 0);

        // R4 enable queue mode
        ctl_write(4'h1);
        check("R4 qmode readback", int'(ctl_rdata), 1);

        // R2 R7 fill transmit queue, 17th write dropped
        for (int k = 0; k < 17; k++) begin
            int e;
            host_tx_we = 1'b1; host_tx_data = 8'(8'h30 + k);
            step();
            host_tx_we = 1'b0;
            e = (k + 1 > 16) ? 16 : k + 1;
            check("R2 tx count", int'(fifo_index[4:0]), e);
            check("R7 tx_almost_empty", int'(tx_almost_empty), (e <= 4) ? 1 : 0);
            check("R7 tx_empty", int'(tx_empty), 0);
        end
        // R2 R7 drain in order
        for (int k = 0; k < 16; k++) begin
            check("R2 tx order", int'(txs_data), 8'h30 + k);
            check("R2 txs_avail", int'(txs_avail), 1);
            txs_pop = 1'b1;
            step();
            txs_pop = 1'b0;
            check("R2 tx count drain", int'(fifo_index[4:0]), 15 - k);
            check("R7 tx_empty drain", int'(tx_empty), (k == 15) ? 1 : 0);
            check("R7 tx_almost_empty drain", int'(tx_almost_empty), (15 - k <= 4) ? 1 : 0);
            check("R6 no underrun", int'(tx_underrun), 0);
        end

        // R6 underrun
        txs_pop = 1'b1;
        step();
        txs_pop = 1'b0;
        check("R6 underrun pulse", int'(tx_underrun), 1);
        check("R6 tx count stays", int'(fifo_index[4:0]), 0);
        step();
        check("R6 underrun one cycle", int'(tx_underrun), 0);

        // R3 R5 R8 fill receive queue, 17th push lost
        for (int k = 0; k < 17; k++) begin
            int e;
            rxs_push = 1'b1; rxs_data = rx_entry(k);
            step();
            rxs_push = 1'b0;
            e = (k + 1 > 16) ? 16 : k + 1;
            check("R3 rx count", int'(fifo_index[12:8]), e);
            check("R8 rx_almost_full", int'(rx_almost_full), (e >= 12) ? 1 : 0);
            check("R8 rx_full", int'(rx_full), (e == 16) ? 1 : 0);
            check("R5 overrun", int'(rx_overrun), (k == 16) ? 1 : 0);
        end
        step();
        check("R5 overrun one cycle", int'(rx_overrun), 0);

        // R3 R10 read back in order, no error while not empty
        err_on_empty = 1'b1;
        for (int k = 0; k < 16; k++) begin
            host_rx_re = 1'b1;
            #1;
            check("R3 rx entry", int'(host_rx_data), int'(rx_entry(k)));
            check("R10 no err when data", int'(host_rx_err), 0);
            step();
            host_rx_re = 1'b0;
        end
        check("R3 rx drained", int'(fifo_index[12:8]), 0);

        // R10 empty read
        err_on_empty = 1'b0;
        host_rx_re = 1'b1;
        #1;
        check("R10 err off", int'(host_rx_err), 0);
        err_on_empty = 1'b1;
        #1;
        check("R10 err on", int'(host_rx_err), 1);
        step();
        host_rx_re = 1'b0;
        check("R10 count stays", int'(fifo_index[12:8]), 0);

        // R11 simultaneous push and pop on full queue
        for (int k = 0; k < 16; k++) begin
            rxs_push = 1'b1; rxs_data = rx_entry(k);
            step();
        end
        rxs_data = rx_entry(40);
        host_rx_re = 1'b1;
        step();
        rxs_push = 1'b0; host_rx_re = 1'b0;
        check("R11 count stays", int'(fifo_index[12:8]), 16);
        check("R11 no overrun", int'(rx_overrun), 0);
        check("R11 head advanced", int'(host_rx_data), int'(rx_entry(1)));

        // R9 transmit flush leaves receive alone
        for (int k = 0; k < 3; k++) begin
            host_tx_we = 1'b1; host_tx_data = 8'(k);
            step();
        end
        host_tx_we = 1'b0;
        ctl_write(4'h5);
        check("R9 tx flush bit set", int'(ctl_rdata), 5);
        check("R9 tx count before", int'(fifo_index[4:0]), 3);
        step();
        check("R9 tx flush bit clear", int'(ctl_rdata), 1);
        check("R9 tx flushed", int'(fifo_index[4:0]), 0);
        check("R9 rx untouched", int'(fifo_index[12:8]), 16);
        ctl_write(4'h9);
        check("R9 rx flush bit set", int'(ctl_rdata), 9);
        step();
        check("R9 rx flush bit clear", int'(ctl_rdata), 1);
        check("R9 rx flushed", int'(fifo_index[12:8]), 0);

        // R4 single-entry mode
        ctl_write(4'h0);
        for (int k = 0; k < 2; k++) begin
            rxs_push = 1'b1; rxs_data = rx_entry(k + 5);
            host_tx_we = 1'b1; host_tx_data = 8'(8'h50 + k);
            step();
            rxs_push = 1'b0; host_tx_we = 1'b0;
            check("R4 rx capacity one", int'(fifo_index[12:8]), 1);
            check("R4 tx capacity one", int'(fifo_index[4:0]), 1);
            check("R8 rx_full single", int'(rx_full), 1);
            check("R5 overrun single", int'(rx_overrun), k);
        end
        check("R4 rx kept first", int'(host_rx_data), int'(rx_entry(5)));
        check("R4 tx kept first", int'(txs_data), 8'h50);
        rx_tx_cnt = int'(fifo_index[12:8]) + int'(fifo_index[4:0]);
        check("R4 total held", rx_tx_cnt, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule